// File: doc/BRIEF.md
# Bus Request to AXI4 Burst Translator

The translator takes one request from a processor-side local bus and turns it into one or two AXI4 address-channel bursts. A request carries a start address, a kind (single, fixed-length burst or cache line), a byte-enable mask, a beat count and a flag that says whether the requester moves 32-bit or 64-bit beats. From these the block works out the AXI burst type, the encoded length (beats minus one) and the encoded size (log2 of bytes per beat). It also converts between the requester's width and the AXI data width by changing the beat count.

An INCR burst that would run past a 4 KB address boundary is cut into two bursts. The first ends just below the boundary. The second starts on the boundary and carries the remaining beats. Requests that cannot be translated are accepted and then dropped, and each one raises a length-error flag. The block also keeps sticky flags for bus error responses. Each flag can be routed to a single interrupt line through its own enable bit.

Only the address channel and the per-request byte-lane masks are modelled. The data FIFOs and the upstream handshake belong to neighbouring blocks.

Top module: `axb_xlate`

## Requirements
- R1: A single request becomes an INCR burst (ax_burst 2'b01) whose beat size is log2 of the smaller of the requester width and the AXI width. It has one beat, or two beats (ax_len 1, ax_size 2) when a 64-bit requester meets a 32-bit AXI side. The address is aligned down to the requester's beat width.
- R2: For a single request the lane mask holds the byte enables. A 64-bit requester uses req_be[7:0] unchanged. A 32-bit requester uses req_be[3:0], placed in bits 7:4 when req_addr[2] is 1 and in bits 3:0 otherwise. The mask drives wstrb on writes and rd_keep on reads, and the other output reads zero.
- R3: A fixed-length burst (req_kind 1) becomes an INCR burst. Its beat count is req_beats, or twice req_beats when a 64-bit requester meets a 32-bit AXI side. Its size follows R1. Both masks other than the zeroed one read 8'hFF.
- R4: A cache-line request (req_kind 2) with req_beats 4 or 8 becomes a WRAP burst (ax_burst 2'b10) with the beat count of R3. Any other line length is rejected.
- R5: An INCR burst that would pass a 4 KB boundary is split into two bursts. The first ends on the last beat below the boundary. The second starts at the boundary address with the remaining beats. The second appears only after the first has been accepted.
- R6: A request whose AXI beat count is 0 or above 256, a bad line length, or req_kind 3 issues no burst and raises a pulse that sets the length-error flag.
- R7: req_ready is high only while no burst is pending. ax_valid and every address field hold steady until ax_ready is seen high.
- R8: Error flags are sticky. Bit 0 is set by resp_code 2'b11 (decode error), bit 1 by resp_code 2'b10 (slave error) and bit 2 by a rejected request. Other codes are ignored. A flag_clr bit clears its flag, and a set in the same cycle wins.
- R9: irq is the OR of each flag ANDed with its enable bit. en_we loads en_wdata into the enables.
- R10: After reset ax_valid is 0, req_ready is 1, all flags and enables are 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 single, 1 burst, 2 cache line |
| req_addr | input | 32 | Request start address |
| req_be | input | 8 | Byte enables for single requests |
| req_beats | input | 9 | Beat count in requester beats |
| req_wide | input | 1 | 1 = 64-bit requester, 0 = 32-bit |
| ax_valid | output | 1 | Address channel valid |
| ax_ready | input | 1 | Address channel ready |
| ax_write | output | 1 | Burst is a write (selects AW over AR) |
| ax_addr | output | 32 | Burst start address |
| ax_len | output | 8 | Beats minus one |
| ax_size | output | 3 | log2 bytes per beat |
| ax_burst | output | 2 | 01 INCR, 10 WRAP |
| wstrb | output | 8 | Write byte strobes for the request |
| rd_keep | output | 8 | Read byte lanes to keep |
| resp_valid | input | 1 | Response code present |
| resp_code | input | 2 | AXI response code |
| en_we | input | 1 | Load interrupt enables |
| en_wdata | input | 3 | New enable bits |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| irq | output | 1 | Interrupt |

## Verification
The assertions rely on three things. Requests of kind 1 start on a requester-beat-aligned address. Cache-line requests sit inside one line, so a WRAP burst never nears a 4 KB edge. ax_ready is only looked at while ax_valid is high. The directed stimulus keeps to these rules: every burst address is a multiple of the requester beat width, and every line address lies inside its line. It also drives a second instance built for a 32-bit AXI side with the same inputs, so both width pairings are exercised in the same cycles.

// File: rtl/axb_pkg.sv
package axb_pkg;
  localparam int AXB_AW = 32;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_BURST  = 2'd1,
    KIND_LINE   = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] BURST_WRAP = 2'b10;

  typedef struct packed {
    logic [AXB_AW-1:0] addr;
    logic [7:0]        len;
    logic [2:0]        size;
    logic [1:0]        burst;
  } axb_cmd_t;

  // beat size code: the narrower of the two sides
  function automatic logic [2:0] beat_size(input logic [2:0] a, input logic [2:0] b);
    return (a < b) ? a : b;
  endfunction

  // number of beats of size 2**sz that fit before the next 4 KB boundary
  function automatic logic [12:0] room_to_4k(input logic [11:0] off, input logic [2:0] sz);
    return (13'd4096 - {1'b0, off}) >> sz;
  endfunction
endpackage

// File: rtl/axb_plan.sv
module axb_plan
  import axb_pkg::*;
#(
  parameter int AXI_DW    = 64,
  parameter int BEAT_W    = 9,
  parameter int MAX_BEATS = 256
) (
  input  logic              req_wide,
  input  logic [1:0]        req_kind,
  input  logic [AXB_AW-1:0] req_addr,
  input  logic [7:0]        req_be,
  input  logic [BEAT_W-1:0] req_beats,
  output logic              bad,
  output logic              split,
  output axb_cmd_t          first,
  output axb_cmd_t          second,
  output logic [7:0]        lane
);
  localparam int BW = BEAT_W + 1;
  localparam logic [2:0] AB_LOG = (AXI_DW == 64) ? 3'd3 : 3'd2;

  req_kind_e         kind;
  logic [2:0]        rb_log, sz;
  logic              dbl;
  logic [BW-1:0]     beats;
  logic [12:0]       beats13, room;
  logic [AXB_AW-1:0] addr_al;

  always_comb begin
    kind    = req_kind_e'(req_kind);
    rb_log  = req_wide ? 3'd3 : 3'd2;
    sz      = beat_size(rb_log, AB_LOG);
    dbl     = req_wide && (AB_LOG == 3'd2);
    if (kind == KIND_SINGLE) beats = dbl ? BW'(2) : BW'(1);
    else                     beats = dbl ? {req_beats, 1'b0} : {1'b0, req_beats};
    beats13 = 13'(beats);
    addr_al = req_addr & ~((AXB_AW'(1) << rb_log) - AXB_AW'(1));
    room    = room_to_4k(addr_al[11:0], sz);

    bad = (kind == KIND_RSVD)
       || ((kind != KIND_SINGLE) && ((beats == '0) || (beats > BW'(MAX_BEATS))))
       || ((kind == KIND_LINE) && !((req_beats == BEAT_W'(4)) || (req_beats == BEAT_W'(8))));
    split = (kind == KIND_BURST) && !bad && (beats13 > room);

    first.addr   = addr_al;
    first.size   = sz;
    first.burst  = (kind == KIND_LINE) ? BURST_WRAP : BURST_INCR;
    first.len    = 8'(split ? (room - 13'd1) : (beats13 - 13'd1));

    second.addr  = {addr_al[AXB_AW-1:12] + {{(AXB_AW-13){1'b0}}, 1'b1}, 12'h000};
    second.size  = sz;
    second.burst = BURST_INCR;
    second.len   = 8'(beats13 - room - 13'd1);

    if (kind == KIND_SINGLE)
      lane = req_wide ? req_be : (req_addr[2] ? {req_be[3:0], 4'h0} : {4'h0, req_be[3:0]});
    else
      lane = 8'hFF;
  end
endmodule

// File: rtl/axb_issue.sv
module axb_issue
  import axb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              bad,
  input  logic              split,
  input  axb_cmd_t          first,
  input  axb_cmd_t          second,
  input  logic [7:0]        lane,
  output logic              req_ready,
  output logic              len_err,
  output logic              ax_valid,
  input  logic              ax_ready,
  output logic              ax_write,
  output axb_cmd_t          cmd,
  output logic [7:0]        wstrb,
  output logic [7:0]        rd_keep
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_e;

  st_e        st;
  axb_cmd_t   second_q;
  logic       split_q;
  logic [7:0] lane_q;
  logic       req_fire, ax_fire;

  assign req_ready = (st == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign ax_fire   = ax_valid && ax_ready;
  assign len_err   = req_fire && bad;
  assign ax_valid  = (st != ST_IDLE);
  assign wstrb     = ax_write ? lane_q : 8'h00;
  assign rd_keep   = ax_write ? 8'h00 : lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cmd      <= '0;
      second_q <= '0;
      split_q  <= 1'b0;
      lane_q   <= 8'h00;
      ax_write <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_fire && !bad) begin
          cmd      <= first;
          second_q <= second;
          split_q  <= split;
          lane_q   <= lane;
          ax_write <= req_write;
          st       <= ST_FIRST;
        end
        ST_FIRST: if (ax_fire) begin
          if (split_q) begin
            cmd <= second_q;
            st  <= ST_SECOND;
          end else begin
            st  <= ST_IDLE;
          end
        end
        ST_SECOND: if (ax_fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && !ax_ready |=> ax_valid && $stable(cmd) && $stable(ax_write)); // R7
  AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && (cmd.burst == BURST_INCR) |->
      (({2'b00, cmd.addr[11:0]} + ((14'(cmd.len) + 14'd1) << cmd.size)) <= 14'd4096)); // R5
  AST_WRAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && (cmd.burst == BURST_WRAP) |->
      (cmd.len == 8'd3 || cmd.len == 8'd7 || cmd.len == 8'd15)); // R4
  AST_SECOND_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ax_fire && (st == ST_FIRST) && split_q |=> ax_valid && (cmd.addr[11:0] == 12'h000)); // R5
  AST_REJECT_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !ax_valid); // R6
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ax_valid); // R7
endmodule

// File: rtl/axb_err.sv
module axb_err #(
  parameter int ERR_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resp_valid,
  input  logic [1:0]       resp_code,
  input  logic             len_err,
  input  logic             en_we,
  input  logic [ERR_N-1:0] en_wdata,
  input  logic [ERR_N-1:0] flag_clr,
  output logic             irq
);
  logic [ERR_N-1:0] flags, en, set_vec;

  always_comb begin
    set_vec    = '0;
    set_vec[0] = resp_valid && (resp_code == 2'b11);
    set_vec[1] = resp_valid && (resp_code == 2'b10);
    set_vec[2] = len_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | set_vec;
      if (en_we) en <= en_wdata;
    end
  end

  assign irq = |(flags & en);

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(resp_valid || len_err || en_we)); // R9
  AST_FLAG_ONLY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> (|$past(flag_clr))); // R8
endmodule

// File: rtl/axb_xlate.sv
module axb_xlate
  import axb_pkg::*;
#(
  parameter int AXI_DW    = 64,
  parameter int BEAT_W    = 9,
  parameter int MAX_BEATS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [AXB_AW-1:0] req_addr,
  input  logic [7:0]        req_be,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_wide,
  output logic              ax_valid,
  input  logic              ax_ready,
  output logic              ax_write,
  output logic [AXB_AW-1:0] ax_addr,
  output logic [7:0]        ax_len,
  output logic [2:0]        ax_size,
  output logic [1:0]        ax_burst,
  output logic [7:0]        wstrb,
  output logic [7:0]        rd_keep,
  input  logic              resp_valid,
  input  logic [1:0]        resp_code,
  input  logic              en_we,
  input  logic [2:0]        en_wdata,
  input  logic [2:0]        flag_clr,
  output logic              irq
);
  localparam int ERR_N = 3;

  logic       bad, split, len_err;
  axb_cmd_t   first, second, cmd;
  logic [7:0] lane;

  axb_plan #(.AXI_DW(AXI_DW), .BEAT_W(BEAT_W), .MAX_BEATS(MAX_BEATS)) plan_i (
    .req_wide(req_wide), .req_kind(req_kind), .req_addr(req_addr), .req_be(req_be),
    .req_beats(req_beats), .bad(bad), .split(split), .first(first), .second(second),
    .lane(lane));

  axb_issue issue_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .bad(bad),
    .split(split), .first(first), .second(second), .lane(lane), .req_ready(req_ready),
    .len_err(len_err), .ax_valid(ax_valid), .ax_ready(ax_ready), .ax_write(ax_write),
    .cmd(cmd), .wstrb(wstrb), .rd_keep(rd_keep));

  axb_err #(.ERR_N(ERR_N)) err_i (
    .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_code(resp_code),
    .len_err(len_err), .en_we(en_we), .en_wdata(en_wdata), .flag_clr(flag_clr), .irq(irq));

  assign ax_addr  = cmd.addr;
  assign ax_len   = cmd.len;
  assign ax_size  = cmd.size;
  assign ax_burst = cmd.burst;
endmodule

// File: tb/axb_xlate_tb.sv
module axb_xlate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_wide = 0;
  logic [1:0]  req_kind = 0;
  logic [31:0] req_addr = 0;
  logic [7:0]  req_be = 0;
  logic [8:0]  req_beats = 0;
  logic        ax_ready = 0, resp_valid = 0, en_we = 0;
  logic [1:0]  resp_code = 0;
  logic [2:0]  en_wdata = 0, flag_clr = 0;

  logic        rdy_w, val_w, wr_w, irq_w;
  logic [31:0] addr_w;
  logic [7:0]  len_w, strb_w, keep_w;
  logic [2:0]  size_w;
  logic [1:0]  burst_w;
  logic        rdy_n, val_n, wr_n, irq_n;
  logic [31:0] addr_n;
  logic [7:0]  len_n, strb_n, keep_n;
  logic [2:0]  size_n;
  logic [1:0]  burst_n;

  int checks = 0, failures = 0;
  bit done = 0;

  axb_xlate #(.AXI_DW(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w), .req_write(req_write),
    .req_kind(req_kind), .req_addr(req_addr), .req_be(req_be), .req_beats(req_beats),
    .req_wide(req_wide), .ax_valid(val_w), .ax_ready(ax_ready), .ax_write(wr_w),
    .ax_addr(addr_w), .ax_len(len_w), .ax_size(size_w), .ax_burst(burst_w), .wstrb(strb_w),
    .rd_keep(keep_w), .resp_valid(resp_valid), .resp_code(resp_code), .en_we(en_we),
    .en_wdata(en_wdata), .flag_clr(flag_clr), .irq(irq_w));

  axb_xlate #(.AXI_DW(32)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_n), .req_write(req_write),
    .req_kind(req_kind), .req_addr(req_addr), .req_be(req_be), .req_beats(req_beats),
    .req_wide(req_wide), .ax_valid(val_n), .ax_ready(ax_ready), .ax_write(wr_n),
    .ax_addr(addr_n), .ax_len(len_n), .ax_size(size_n), .ax_burst(burst_n), .wstrb(strb_n),
    .rd_keep(keep_n), .resp_valid(resp_valid), .resp_code(resp_code), .en_we(en_we),
    .en_wdata(en_wdata), .flag_clr(flag_clr), .irq(irq_n));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // side 0: 64-bit AXI instance, side 1: 32-bit AXI instance
  task automatic chk_cmd(input string req, input int side, input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [1:0] b);
    if (side == 0) begin
      chk(req, "valid64", val_w, 1); chk(req, "addr64", addr_w, a);
      chk(req, "len64", len_w, l);   chk(req, "size64", size_w, s); chk(req, "burst64", burst_w, b);
    end else begin
      chk(req, "valid32", val_n, 1); chk(req, "addr32", addr_n, a);
      chk(req, "len32", len_n, l);   chk(req, "size32", size_n, s); chk(req, "burst32", burst_n, b);
    end
  endtask

  task automatic send(input logic wr, input logic [1:0] kind, input logic [31:0] a,
                      input logic [7:0] be, input logic [8:0] beats, input logic wide);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_kind = kind; req_addr = a;
    req_be = be; req_beats = beats; req_wide = wide;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic accept();
    ax_ready = 1;
    @(negedge clk);
    ax_ready = 0;
  endtask

  task automatic set_en(input logic [2:0] v);
    en_we = 1; en_wdata = v; @(negedge clk); en_we = 0;
  endtask

  task automatic clr(input logic [2:0] v);
    flag_clr = v; @(negedge clk); flag_clr = 0;
  endtask

  task automatic resp(input logic [1:0] c);
    resp_valid = 1; resp_code = c; @(negedge clk); resp_valid = 0;
  endtask

  task automatic t_reset();
    chk("R10", "valid64", val_w, 0); chk("R10", "ready64", rdy_w, 1); chk("R10", "irq64", irq_w, 0);
    chk("R10", "valid32", val_n, 0); chk("R10", "ready32", rdy_n, 1); chk("R10", "irq32", irq_n, 0);
  endtask

  task automatic t_single();
    send(1, 2'd0, 32'h1004, 8'h06, 9'd1, 0);
    chk_cmd("R1", 0, 32'h1004, 8'd0, 3'd2, 2'b01);
    chk_cmd("R1", 1, 32'h1004, 8'd0, 3'd2, 2'b01);
    chk("R2", "wstrb64", strb_w, 8'h60); chk("R2", "keep64", keep_w, 8'h00);
    chk("R2", "wstrb32", strb_n, 8'h60);
    accept();
    send(0, 2'd0, 32'h200B, 8'h0F, 9'd1, 1);
    chk_cmd("R1", 0, 32'h2008, 8'd0, 3'd3, 2'b01);
    chk_cmd("R1", 1, 32'h2008, 8'd1, 3'd2, 2'b01);
    chk("R2", "keep64", keep_w, 8'h0F); chk("R2", "wstrb64", strb_w, 8'h00);
    chk("R2", "keep32", keep_n, 8'h0F);
    accept();
    chk("R7", "ready after accept", rdy_w, 1);
  endtask

  task automatic t_burst();
    send(1, 2'd1, 32'h0100, 8'h00, 9'd16, 0);
    chk_cmd("R3", 0, 32'h0100, 8'd15, 3'd2, 2'b01);
    chk_cmd("R3", 1, 32'h0100, 8'd15, 3'd2, 2'b01);
    chk("R3", "wstrb64", strb_w, 8'hFF);
    accept();
    send(0, 2'd1, 32'h0200, 8'h00, 9'd16, 1);
    chk_cmd("R3", 0, 32'h0200, 8'd15, 3'd3, 2'b01);
    chk_cmd("R3", 1, 32'h0200, 8'd31, 3'd2, 2'b01);
    chk("R3", "keep32", keep_n, 8'hFF);
    accept();
  endtask

  task automatic t_line();
    send(0, 2'd2, 32'h3010, 8'h00, 9'd8, 1);
    chk_cmd("R4", 0, 32'h3010, 8'd7, 3'd3, 2'b10);
    chk_cmd("R4", 1, 32'h3010, 8'd15, 3'd2, 2'b10);
    accept();
    send(0, 2'd2, 32'h3000, 8'h00, 9'd6, 0);
    chk("R4", "bad line no burst64", val_w, 0); chk("R4", "bad line no burst32", val_n, 0);
    chk("R6", "ready after reject", rdy_w, 1);
    set_en(3'b100);
    chk("R6", "len flag irq64", irq_w, 1); chk("R6", "len flag irq32", irq_n, 1);
    clr(3'b100);
    chk("R8", "cleared irq64", irq_w, 0);
    set_en(3'b000);
  endtask

  task automatic t_split();
    send(1, 2'd1, 32'h0FF8, 8'h00, 9'd16, 0);
    chk_cmd("R5", 0, 32'h0FF8, 8'd1, 3'd2, 2'b01);
    chk_cmd("R5", 1, 32'h0FF8, 8'd1, 3'd2, 2'b01);
    chk("R7", "ready busy", rdy_w, 0);
    @(negedge clk); @(negedge clk);
    chk_cmd("R7", 0, 32'h0FF8, 8'd1, 3'd2, 2'b01);
    accept();
    chk_cmd("R5", 0, 32'h1000, 8'd13, 3'd2, 2'b01);
    chk_cmd("R5", 1, 32'h1000, 8'd13, 3'd2, 2'b01);
    chk("R7", "ready during second", rdy_w, 0);
    accept();
    chk("R5", "idle after second", val_w, 0); chk("R5", "idle after second32", val_n, 0);
  endtask

  task automatic t_limit();
    send(0, 2'd1, 32'h0000, 8'h00, 9'd256, 1);
    chk_cmd("R6", 0, 32'h0000, 8'd255, 3'd3, 2'b01);
    chk("R6", "over 256 rejected32", val_n, 0);
    accept();
    set_en(3'b100);
    chk("R6", "no len flag64", irq_w, 0); chk("R6", "len flag32", irq_n, 1);
    clr(3'b100);
    send(0, 2'd1, 32'h0000, 8'h00, 9'd0, 0);
    chk("R6", "zero beats64", val_w, 0); chk("R6", "zero beats32", val_n, 0);
    chk("R6", "zero flag64", irq_w, 1);
    clr(3'b100);
    set_en(3'b000);
  endtask

  task automatic t_irq();
    resp(2'b10);
    chk("R9", "masked slverr", irq_w, 0);
    set_en(3'b010);
    chk("R9", "enabled slverr", irq_w, 1);
    clr(3'b010);
    chk("R8", "slverr cleared", irq_w, 0);
    resp(2'b11);
    chk("R9", "decerr masked", irq_w, 0);
    set_en(3'b001);
    chk("R9", "decerr enabled", irq_w, 1);
    resp_valid = 1; resp_code = 2'b11; flag_clr = 3'b001;
    @(negedge clk);
    resp_valid = 0; flag_clr = 0;
    chk("R8", "set wins over clear", irq_w, 1);
    clr(3'b001);
    resp(2'b00);
    set_en(3'b011);
    chk("R8", "okay ignored", irq_w, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_line();
    t_split();
    t_limit();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule